// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of every beat of a pipelined bus burst. A master presents a start pulse with the first address, the transfer size and the burst kind. From the next cycle on, the block drives the address of the current beat. Each time the slave signals ready, the block moves to the address of the next beat. In this way the next address is already on the bus while the data of the current beat is still completing.

Incrementing bursts count upward by the transfer size. Wrapping bursts stay inside an aligned window whose size is the beat count times the transfer size, and fold back to the bottom of that window when they reach its top. Fixed-length bursts flag their final beat and then return to idle. An undefined-length incrementing burst runs until the master drops its continue input.

Top module: `burst_addr_gen`

## Requirements
- R1: For incrementing kinds, each beat accepted with `ready_i` high makes the following beat's address equal to the current address plus the transfer size in bytes. The size is 0 for one byte, 1 for two bytes and 2 for four bytes. A 4-beat incrementing burst of 4-byte beats starting at 0x64 yields 0x64, 0x68, 0x6C, 0x70.
- R2: For wrapping kinds, the address bits below the boundary (beats × bytes) step upward and roll over, while the bits above it stay fixed. A 4-beat wrapping burst of 4-byte beats starting at 0x64 yields 0x64, 0x68, 0x6C, 0x60.
- R3: `kind_i` is decoded as 0 single, 1 undefined-length incrementing, 2 wrap4, 3 incr4, 4 wrap8, 5 incr8, 6 wrap16, 7 incr16. A fixed kind lasts exactly 1, 4, 8 or 16 beats.
- R4: While `active_o` is high and `ready_i` is low, `addr_o`, `last_o` and the beat position hold their values.
- R5: `last_o` is high exactly on the final beat of a fixed-length burst, a single transfer included. After that beat is accepted, `active_o` falls on the next cycle.
- R6: An undefined-length burst never raises `last_o`. It ends after a beat accepted with `ready_i` high while `cont_i` is low.
- R7: A start pulse is taken only while idle. The first beat's address appears on `addr_o` in the cycle after the pulse. A start pulse during an active burst has no effect on the sequence.
- R8: Synchronous reset clears `active_o`, `last_o` and `addr_o` to zero, including in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a new burst |
| start_addr_i | input | ADDR_W | First beat address |
| size_i | input | 2 | Transfer size code (0 byte, 1 halfword, 2 word) |
| kind_i | input | 3 | Burst kind code |
| ready_i | input | 1 | Slave ready; current beat completes when high |
| cont_i | input | 1 | Keeps an undefined-length burst running |
| addr_o | output | ADDR_W | Address of the current beat |
| active_o | output | 1 | A burst is in progress |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The assertions assume that `size_i` never carries the unused code 3. They also assume that a wrapping burst's start address is aligned to its transfer size, because otherwise the step arithmetic would carry low bits that the window mask does not describe. Every burst in the stimulus uses a legal size code with a size-aligned start. Unaligned wrap starts are exercised only at the window level, never at the byte level. Start pulses issued during an active burst are deliberate, so that the check that they are ignored has something to observe.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    KIND_SINGLE = 3'd0,
    KIND_UNDEF  = 3'd1,
    KIND_WRAP4  = 3'd2,
    KIND_INCR4  = 3'd3,
    KIND_WRAP8  = 3'd4,
    KIND_INCR8  = 3'd5,
    KIND_WRAP16 = 3'd6,
    KIND_INCR16 = 3'd7
  } burst_kind_e;

  localparam int unsigned MAX_BEATS = 16;
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS);
endpackage

// File: rtl/burst_kind_decode.sv
module burst_kind_decode
  import burst_pkg::*;
(
  input  logic [2:0]       kind,
  output logic [CNT_W-1:0] beats_m1,
  output logic             is_wrap,
  output logic             is_undef
);
  always_comb begin
    is_undef = (kind == KIND_UNDEF);
    is_wrap  = (kind != KIND_SINGLE) && !kind[0];
    unique case (kind[2:1])
      2'd0:    beats_m1 = '0;
      2'd1:    beats_m1 = CNT_W'(3);
      2'd2:    beats_m1 = CNT_W'(7);
      default: beats_m1 = CNT_W'(15);
    endcase
  end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        size,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] win_mask,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    step = ADDR_W'(1) << size;
    sum  = cur + step;
    if (wrap) nxt = (cur & ~win_mask) | (sum & win_mask);
    else      nxt = sum;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        kind_i,
  input  logic              ready_i,
  input  logic              cont_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o,
  output logic              last_o
);
  logic [CNT_W-1:0]  dec_beats_m1;
  logic              dec_wrap, dec_undef;
  logic [CNT_W-1:0]  remain_q;
  logic [1:0]        size_q;
  logic              wrap_q, undef_q;
  logic [ADDR_W-1:0] mask_q, mask_d, nxt_addr;

  burst_kind_decode u_dec (
    .kind     (kind_i),
    .beats_m1 (dec_beats_m1),
    .is_wrap  (dec_wrap),
    .is_undef (dec_undef)
  );

  // window is (beats * bytes) - 1, beats a power of two
  always_comb mask_d = ((ADDR_W'(dec_beats_m1) + ADDR_W'(1)) << size_i) - ADDR_W'(1);

  burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .cur      (addr_o),
    .size     (size_q),
    .wrap     (wrap_q),
    .win_mask (mask_q),
    .nxt      (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o   <= '0;
      active_o <= 1'b0;
      last_o   <= 1'b0;
      remain_q <= '0;
      size_q   <= '0;
      wrap_q   <= 1'b0;
      undef_q  <= 1'b0;
      mask_q   <= '0;
    end else if (!active_o) begin
      if (start_i) begin
        addr_o   <= start_addr_i;
        active_o <= 1'b1;
        last_o   <= !dec_undef && (dec_beats_m1 == '0);
        remain_q <= dec_beats_m1;
        size_q   <= size_i;
        wrap_q   <= dec_wrap;
        undef_q  <= dec_undef;
        mask_q   <= mask_d;
      end
    end else if (ready_i) begin
      if (last_o || (undef_q && !cont_i)) begin
        active_o <= 1'b0;
        last_o   <= 1'b0;
      end else begin
        addr_o <= nxt_addr;
        if (!undef_q) begin
          remain_q <= remain_q - CNT_W'(1);
          last_o   <= (remain_q == CNT_W'(1));
        end
      end
    end
  end

  // R4
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && !ready_i) |=> ($stable(addr_o) && $stable(last_o) && active_o));

  // R5
  last_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && last_o && ready_i) |=> !active_o);

  // R6
  undef_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && undef_q) |-> !last_o);

  // R2
  wrap_window_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && ready_i && wrap_q && !last_o) |=>
      ((addr_o & ~mask_q) == ($past(addr_o) & ~mask_q)));

  // R1
  incr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && ready_i && !wrap_q && !last_o && (!undef_q || cont_i)) |=>
      (addr_o == $past(addr_o) + (ADDR_W'(1) << size_q)));

  // R7
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_o && start_i) |=> (active_o && addr_o == $past(start_addr_i)));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [31:0] start_addr_i;
  logic [1:0]  size_i;
  logic [2:0]  kind_i;
  logic        ready_i;
  logic        cont_i;
  logic [31:0] addr_o;
  logic        active_o;
  logic        last_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(32)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .size_i(size_i), .kind_i(kind_i), .ready_i(ready_i), .cont_i(cont_i),
    .addr_o(addr_o), .active_o(active_o), .last_o(last_o)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic [2:0]  k;
    logic [31:0] e0, e1, e2, e3;
    logic [4:0]  n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h64,  2'd2, 3'd3, 32'h64,  32'h68,  32'h6C,  32'h70,  5'd4},
    '{32'h64,  2'd2, 3'd2, 32'h64,  32'h68,  32'h6C,  32'h60,  5'd4},
    '{32'h3A,  2'd1, 3'd4, 32'h3A,  32'h3C,  32'h3E,  32'h30,  5'd8},
    '{32'h10,  2'd0, 3'd5, 32'h10,  32'h11,  32'h12,  32'h13,  5'd8},
    '{32'h134, 2'd2, 3'd6, 32'h134, 32'h138, 32'h13C, 32'h100, 5'd16},
    '{32'h200, 2'd1, 3'd7, 32'h200, 32'h202, 32'h204, 32'h206, 5'd16},
    '{32'h55,  2'd0, 3'd0, 32'h55,  32'h0,   32'h0,   32'h0,   5'd1},
    '{32'h60,  2'd2, 3'd2, 32'h60,  32'h64,  32'h68,  32'h6C,  5'd4}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] k);
    start_i = 1'b1; start_addr_i = a; size_i = sz; kind_i = k;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; start_addr_i = '0; size_i = '0; kind_i = '0;
    ready_i = 1'b1; cont_i = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!active_o && !last_o && addr_o == 0, "R8 reset", {active_o, last_o, addr_o[29:0]}, 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: R1 R2 R3 R5 R7
    for (int v = 0; v < NV; v++) begin
      launch(VECS[v].a, VECS[v].sz, VECS[v].k);
      for (int i = 0; i < VECS[v].n; i++) begin
        logic [31:0] e;
        e = (i == 0) ? VECS[v].e0 : (i == 1) ? VECS[v].e1 : (i == 2) ? VECS[v].e2 : VECS[v].e3;
        if (i < 4) chk(addr_o == e, $sformatf("R1/R2 vec%0d beat%0d addr", v, i), addr_o, e);
        chk(active_o, $sformatf("R3 vec%0d beat%0d active", v, i), active_o, 1);
        chk(last_o == (i == VECS[v].n - 1), $sformatf("R5 vec%0d beat%0d last", v, i),
            last_o, (i == VECS[v].n - 1));
        @(negedge clk);
      end
      chk(!active_o, $sformatf("R3/R5 vec%0d idle after n beats", v), active_o, 0);
      @(negedge clk);
    end

    // R4 wait states
    launch(32'h0, 2'd2, 3'd3);
    ready_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(addr_o == 0 && active_o && !last_o, "R4 hold during wait", addr_o, 0);
    end
    ready_i = 1'b1;
    @(negedge clk);
    chk(addr_o == 32'h4, "R4 advance after wait", addr_o, 32'h4);
    repeat (3) @(negedge clk);
    chk(!active_o, "R5 idle after waited burst", active_o, 0);

    // R6 undefined-length
    cont_i = 1'b1;
    launch(32'h100, 2'd2, 3'd1);
    for (int i = 0; i < 5; i++) begin
      chk(addr_o == 32'h100 + 4 * i, "R6 undef addr", addr_o, 32'h100 + 4 * i);
      chk(!last_o && active_o, "R6 undef no last", last_o, 0);
      if (i == 4) cont_i = 1'b0;
      @(negedge clk);
    end
    chk(!active_o, "R6 undef ends when cont low", active_o, 0);
    @(negedge clk);

    // R7 start ignored while active
    launch(32'h20, 2'd0, 3'd5);
    chk(addr_o == 32'h20, "R7 first beat", addr_o, 32'h20);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = 32'h900; size_i = 2'd2; kind_i = 3'd0;
    @(negedge clk);
    start_i = 1'b0;
    chk(addr_o == 32'h22 && active_o && !last_o, "R7 start ignored", addr_o, 32'h22);

    // R8 mid-burst reset
    rst = 1'b1;
    @(negedge clk);
    chk(!active_o && !last_o && addr_o == 0, "R8 mid-burst reset", addr_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!active_o, "R8 stays idle", active_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule